// File: doc/BRIEF.md
# Interlocked Parallel Byte Port

This block moves bytes across an 8-bit parallel port using two handshake lines: an active-low data-available strobe and a ready line. The same pair of lines serves both directions. In input mode an outside sender drives the byte and lowers data-available. The block captures the byte, answers by pulling ready low, and hands the byte to the core over a valid/ready pair. In output mode the block takes a byte from the core, drives it onto the port and lowers data-available. The outside receiver answers on the ready line.

Every step waits for the other side's edge. This four-phase interlock makes the transfer independent of the speed of either party. The two incoming handshake lines are resynchronised to the block clock before the state machines use them. A direction input selects the mode. The block applies a new direction only once the port has returned to idle.

Top module: `hs_port`

## Requirements
- R1: While reset is held, and directly after it, rdy_o and dav_n_o are 1, rx_valid_o, mode_o and data_oe_o are 0, and any held input byte is discarded.
- R2: dav_n_i and rdy_i each pass through a two-stage synchronizer. A change on either pin produces its first output response after the third rising clock edge that follows the change, and not sooner.
- R3: In input mode (mode_o = 0) the byte on data_i is captured when the synchronized dav_n_i is seen low. rx_data_o then keeps that value even if data_i changes later.
- R4: In input mode rdy_o goes low in the same cycle that rx_valid_o rises, in answer to the fall of dav_n_i.
- R5: In input mode rdy_o returns to 1 only when dav_n_i has gone high again and the core has taken the byte. It stays 0 while either condition is missing, which holds off the sender.
- R6: rx_valid_o stays 1 and rx_data_o stays constant until a cycle with rx_valid_o = 1 and rx_ready_i = 1. After that cycle rx_valid_o is 0.
- R7: tx_ready_o is 1 only in output mode (mode_o = 1), with no transfer in progress and the synchronized rdy_i high. A byte is taken from tx_data_i on a clock edge where tx_valid_i and tx_ready_o are both 1.
- R8: In output mode data_o shows the taken byte one cycle before dav_n_o falls, and it stays unchanged while dav_n_o is 0. data_oe_o equals mode_o.
- R9: In output mode dav_n_o rises only after the synchronized rdy_i has been seen low. It stays 0 for as long as rdy_i stays high.
- R10: After dav_n_o rises, no new byte is accepted (tx_ready_o = 0) and dav_n_o stays 1 until rdy_i has risen again.
- R11: mode_o follows dir_i (1 = output, 0 = input) only when neither direction has a transfer in progress. A change requested in the middle of a transfer waits for its end. In output mode rdy_o is held at 1 and dav_n_i is ignored. In input mode dav_n_o is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Requested direction, 1 = output, 0 = input |
| data_i | input | 8 | Port data from outside sender |
| dav_n_i | input | 1 | Data-available from sender, active low |
| rdy_i | input | 1 | Ready from outside receiver |
| data_o | output | 8 | Port data toward receiver |
| data_oe_o | output | 1 | Drive enable for data_o |
| dav_n_o | output | 1 | Data-available toward receiver, active low |
| rdy_o | output | 1 | Ready toward sender |
| mode_o | output | 1 | Direction in effect, 1 = output |
| rx_data_o | output | 8 | Captured byte for the core |
| rx_valid_o | output | 1 | Captured byte waiting |
| rx_ready_i | input | 1 | Core takes the captured byte |
| tx_data_i | input | 8 | Byte from the core to send |
| tx_valid_i | input | 1 | Core offers a byte |
| tx_ready_o | output | 1 | Block takes the offered byte |

## Verification
The bench sends a mixed list of bytes in both directions, including all-zero, all-one and alternating patterns. This shows that the capture and drive paths keep every bit, and that the port turns around cleanly between directions. In the input direction the core's acceptance is delayed in one case and given early in another, while dav_n_i is held low. This separates the two conditions that release rdy_o. In the output direction the receiver's ready is held back on purpose, in both phases, to show that dav_n_o waits for each edge. A direction change requested in mid-transfer, and a reset that arrives with a byte waiting, show that mode changes wait for the transfer to end and that reset discards the held byte.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  typedef enum logic {
    RX_IDLE,
    RX_TAKEN
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SETUP,
    TX_STROBE,
    TX_RELEASE
  } tx_state_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx
  import hs_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dav_n_s_i,
  input  logic [DATA_W-1:0] pin_data_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  input  logic              accept_i,
  output logic              idle_o
);
  rx_state_e         state_q;
  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              acc;

  assign take = en_i && (state_q == RX_IDLE) && !dav_n_s_i;
  assign acc  = pend_q && accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) begin
        data_q  <= pin_data_i;
        pend_q  <= 1'b1;
        state_q <= RX_TAKEN;
      end else begin
        if (acc) pend_q <= 1'b0;
        // release only once strobe is back high and core has the byte
        if (state_q == RX_TAKEN && dav_n_s_i && !pend_q) state_q <= RX_IDLE;
      end
    end
  end

  assign rdy_o   = (state_q != RX_TAKEN);
  assign data_o  = data_q;
  assign valid_o = pend_q;
  assign idle_o  = (state_q == RX_IDLE) && dav_n_s_i;
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx
  import hs_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rdy_s_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              core_valid_i,
  output logic              core_ready_o,
  output logic [DATA_W-1:0] pin_data_o,
  output logic              dav_n_o,
  output logic              idle_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  assign core_ready_o = en_i && (state_q == TX_IDLE) && rdy_s_i;
  assign load         = core_ready_o && core_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (load) begin
          data_q  <= core_data_i;
          state_q <= TX_SETUP;
        end
        TX_SETUP:   state_q <= TX_STROBE;          // data settles before strobe
        TX_STROBE:  if (!rdy_s_i) state_q <= TX_RELEASE;
        TX_RELEASE: if (rdy_s_i) state_q <= TX_IDLE;
        default:    state_q <= TX_IDLE;
      endcase
    end
  end

  assign pin_data_o = data_q;
  assign dav_n_o    = (state_q != TX_STROBE);
  assign idle_o     = (state_q == TX_IDLE) && !load;
endmodule

// File: rtl/hsp_mode.sv
module hsp_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic rx_idle_i,
  input  logic tx_idle_i,
  output logic mode_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= 1'b0;
    else if (rx_idle_i && tx_idle_i)  mode_q <= dir_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dav_n_i,
  input  logic              rdy_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              dav_n_o,
  output logic              rdy_o,
  output logic              mode_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  localparam int unsigned HS_W = 2;

  logic [HS_W-1:0] hs_s;
  logic            dav_n_s;
  logic            rdy_s;
  logic            mode;
  logic            rx_idle;
  logic            tx_idle;
  logic            tx_dav_n;

  hsp_sync #(
    .WIDTH  (HS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({HS_W{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dav_n_i, rdy_i}),
    .q_o   (hs_s)
  );

  assign dav_n_s = hs_s[1];
  assign rdy_s   = hs_s[0];

  hsp_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_i    (dir_i),
    .rx_idle_i(rx_idle),
    .tx_idle_i(tx_idle),
    .mode_o   (mode)
  );

  hsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (!mode),
    .dav_n_s_i (dav_n_s),
    .pin_data_i(data_i),
    .rdy_o     (rdy_o),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .accept_i  (rx_ready_i),
    .idle_o    (rx_idle)
  );

  hsp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mode),
    .rdy_s_i     (rdy_s),
    .core_data_i (tx_data_i),
    .core_valid_i(tx_valid_i),
    .core_ready_o(tx_ready_o),
    .pin_data_o  (data_o),
    .dav_n_o     (tx_dav_n),
    .idle_o      (tx_idle)
  );

  assign dav_n_o   = tx_dav_n || !mode;
  assign data_oe_o = mode;
  assign mode_o    = mode;
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dav_n_i,
  input logic              rdy_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              dav_n_o,
  input logic              rdy_o,
  input logic              mode_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic              tx_ready_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (rdy_o && dav_n_o && !rx_valid_o && !mode_o && !data_oe_o)
        else $error("reset state wrong");
    end
  end

  // R4
  rdy_fall_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $rose(rx_valid_o));

  // R5
  rdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> !rx_valid_o && $past(dav_n_i));

  // R6
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  // R7
  tx_ready_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> mode_o && dav_n_o);

  // R8
  data_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dav_n_o |-> $stable(data_o) && data_oe_o);

  // R9
  dav_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dav_n_o) |-> $past(!rdy_i));

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(rdy_o && dav_n_o && !rx_valid_o));

  // R11
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o ? (rdy_o && !rx_valid_o) : dav_n_o);
endmodule

bind hs_port hs_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dav_n_i   (dav_n_i),
  .rdy_i     (rdy_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .dav_n_o   (dav_n_o),
  .rdy_o     (rdy_o),
  .mode_o    (mode_o),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .tx_ready_o(tx_ready_o)
);

// File: tb/tb_hs_port.sv
module tb_hs_port;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;
  // {direction, byte}
  localparam logic [8:0] VEC [N_VEC] = '{9'h0A5, 9'h13C, 9'h000, 9'h1FF, 9'h15A, 9'h0C3};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dir_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       dav_n_i = 1'b1;
  logic       rdy_i = 1'b1;
  logic [7:0] data_o;
  logic       data_oe_o, dav_n_o, rdy_o, mode_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_ready_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hs_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk_i);
    dir_i = d;
    for (int k = 0; k < 10 && mode_o !== d; k++) @(negedge clk_i);
    chk("R11 mode follows idle request", {31'd0, mode_o}, {31'd0, d});
    chk("R8 data_oe matches mode", {31'd0, data_oe_o}, {31'd0, d});
  endtask

  task automatic in_xfer(input logic [7:0] b);
    @(negedge clk_i);
    data_i = b;
    @(negedge clk_i);
    dav_n_i = 1'b0;
    edges(2);
    chk("R2 rdy_o not yet low", {31'd0, rdy_o}, 32'd1);
    chk("R2 rx_valid_o not yet set", {31'd0, rx_valid_o}, 32'd0);
    edges(1);
    chk("R4 rdy_o low", {31'd0, rdy_o}, 32'd0);
    chk("R4 rx_valid_o set", {31'd0, rx_valid_o}, 32'd1);
    chk("R3 byte captured", {24'd0, rx_data_o}, {24'd0, b});
    data_i = ~b;
    dav_n_i = 1'b1;
    edges(5);
    chk("R5 throttle while unaccepted", {31'd0, rdy_o}, 32'd0);
    chk("R6 byte still valid", {31'd0, rx_valid_o}, 32'd1);
    chk("R3 byte kept after data change", {24'd0, rx_data_o}, {24'd0, b});
    rx_ready_i = 1'b1;
    edges(1);
    rx_ready_i = 1'b0;
    chk("R6 valid cleared on accept", {31'd0, rx_valid_o}, 32'd0);
    chk("R5 rdy_o still low one cycle", {31'd0, rdy_o}, 32'd0);
    edges(1);
    chk("R5 rdy_o back high", {31'd0, rdy_o}, 32'd1);
  endtask

  task automatic out_xfer(input logic [7:0] b);
    @(negedge clk_i);
    chk("R7 tx_ready_o in idle", {31'd0, tx_ready_o}, 32'd1);
    tx_data_i = b;
    tx_valid_i = 1'b1;
    edges(1);
    tx_valid_i = 1'b0;
    tx_data_i = ~b;
    chk("R8 data before strobe", {24'd0, data_o}, {24'd0, b});
    chk("R8 strobe still high", {31'd0, dav_n_o}, 32'd1);
    chk("R7 busy after take", {31'd0, tx_ready_o}, 32'd0);
    edges(1);
    chk("R8 strobe low", {31'd0, dav_n_o}, 32'd0);
    edges(4);
    chk("R9 strobe held while rdy high", {31'd0, dav_n_o}, 32'd0);
    chk("R8 data held under strobe", {24'd0, data_o}, {24'd0, b});
    rdy_i = 1'b0;
    edges(2);
    chk("R2 strobe not yet released", {31'd0, dav_n_o}, 32'd0);
    edges(1);
    chk("R9 strobe released after rdy fall", {31'd0, dav_n_o}, 32'd1);
    edges(4);
    chk("R10 no new take while rdy low", {31'd0, tx_ready_o}, 32'd0);
    chk("R10 strobe stays high", {31'd0, dav_n_o}, 32'd1);
    rdy_i = 1'b1;
    edges(2);
    chk("R10 still busy before rdy synced", {31'd0, tx_ready_o}, 32'd0);
    edges(1);
    chk("R10 ready after rdy rise", {31'd0, tx_ready_o}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    edges(2);
    chk("R1 rdy_o in reset", {31'd0, rdy_o}, 32'd1);
    chk("R1 dav_n_o in reset", {31'd0, dav_n_o}, 32'd1);
    chk("R1 rx_valid_o in reset", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 mode_o in reset", {31'd0, mode_o}, 32'd0);
    rst_ni = 1'b1;
    edges(1);
    chk("R1 data_oe_o after reset", {31'd0, data_oe_o}, 32'd0);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      set_dir(VEC[i][8]);
      if (VEC[i][8]) out_xfer(VEC[i][7:0]);
      else           in_xfer(VEC[i][7:0]);
    end

    // R11 dav_n_i ignored in output mode
    set_dir(1'b1);
    dav_n_i = 1'b0;
    edges(5);
    chk("R11 dav_n_i ignored in output", {31'd0, rx_valid_o}, 32'd0);
    chk("R11 rdy_o held high in output", {31'd0, rdy_o}, 32'd1);
    dav_n_i = 1'b1;
    edges(3);

    // R5 early accept, dav held low
    set_dir(1'b0);
    rx_ready_i = 1'b1;
    data_i = 8'h96;
    dav_n_i = 1'b0;
    edges(3);
    chk("R3 byte with early accept", {24'd0, rx_data_o}, 32'h96);
    edges(6);
    chk("R5 rdy_o low while dav low", {31'd0, rdy_o}, 32'd0);
    chk("R6 accepted byte cleared", {31'd0, rx_valid_o}, 32'd0);
    dav_n_i = 1'b1;
    edges(2);
    chk("R5 rdy_o low before dav synced", {31'd0, rdy_o}, 32'd0);
    edges(1);
    chk("R5 rdy_o high after dav rise", {31'd0, rdy_o}, 32'd1);
    rx_ready_i = 1'b0;

    // R11 direction change during input transfer
    data_i = 8'h21;
    dav_n_i = 1'b0;
    edges(3);
    dir_i = 1'b1;
    edges(3);
    chk("R11 mode held mid-transfer", {31'd0, mode_o}, 32'd0);
    chk("R11 no drive mid-transfer", {31'd0, data_oe_o}, 32'd0);
    dav_n_i = 1'b1;
    edges(3);
    rx_ready_i = 1'b1;
    edges(1);
    rx_ready_i = 1'b0;
    edges(1);
    chk("R5 rdy_o high at end", {31'd0, rdy_o}, 32'd1);
    chk("R11 mode unchanged at end edge", {31'd0, mode_o}, 32'd0);
    edges(1);
    chk("R11 mode switched after idle", {31'd0, mode_o}, 32'd1);

    // R1 reset discards a pending byte
    set_dir(1'b0);
    data_i = 8'h44;
    dav_n_i = 1'b0;
    edges(3);
    chk("R3 pending before reset", {31'd0, rx_valid_o}, 32'd1);
    rst_ni = 1'b0;
    dav_n_i = 1'b1;
    edges(1);
    chk("R1 pending cleared by reset", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 rdy_o high by reset", {31'd0, rdy_o}, 32'd1);
    rst_ni = 1'b1;
    edges(3);
    in_xfer(8'h81);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule